// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block watches the fault flags of a five-stage pipeline and turns a fault into a precise exception. Decode reports an undefined opcode with the PC of the instruction it holds. Execute reports an arithmetic overflow or a divide by zero with the PC of its own instruction. When a fault is taken, the block steers the next fetch to the fixed handler entry 0x8000_0180 in that same cycle. It also raises flush strobes that clear the control bits of the pipeline registers behind the faulting instruction. At the same clock edge it captures the faulting PC in an exception-PC register and a reason code in a cause register.

An execute fault clears the IF/ID, ID/EX and EX/MEM control bits. Clearing EX/MEM removes the register write of the faulting instruction itself, so its destination is left untouched. It also removes the two younger instructions, while the older instructions in MEM and WB run to completion. A decode fault clears only IF/ID and ID/EX, so the older instruction in EX still commits. If both stages fault in one cycle, the older, execute-stage fault wins.

A small state machine tracks the flushed bubbles. It has three states. RUN is the normal state. QUIET is the first cycle after a take: ID and EX both hold bubbles, so both stages' flags are ignored. PARTIAL is the second cycle after a take: EX still holds a bubble, but ID holds the first handler instruction, so only the decode flag counts. The transitions are:
- RUN→QUIET on a take.
- QUIET→PARTIAL always.
- PARTIAL→QUIET on a decode take.
- PARTIAL→RUN otherwise.
- RUN→RUN when no fault occurs.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, the exception PC and the cause register read 0. The redirect and all three flush strobes are low, and the next PC equals the sequential PC.
- R2: In RUN, an execute overflow raises the redirect and all three flushes (IF/ID, ID/EX, EX/MEM) in the same cycle, and the next PC is 0x8000_0180. At the following edge, the exception PC takes the execute PC and the cause register takes 0x30 (code 0x0C in bits [6:2]).
- R3: In RUN, an execute divide-by-zero behaves as in R2, but the cause register takes 0x34 (code 0x0D in bits [6:2]).
- R4: In RUN, a decode undefined opcode raises the redirect, the IF/ID flush and the ID/EX flush, but not the EX/MEM flush. At the following edge, the exception PC takes the decode PC and the cause register takes 0x28 (code 0x0A in bits [6:2]).
- R5: When decode and execute fault in the same cycle, the execute fault is taken: all three flushes rise, and the execute PC and code are recorded.
- R6: When overflow and divide-by-zero are flagged together, the overflow code 0x0C is recorded.
- R7: Without a fault taken, the next PC equals the sequential PC, no strobe rises, and the exception PC and cause hold their values.
- R8: In the cycle after a take, all fault flags are ignored: there is no redirect, no flush, and no change to the exception PC or cause.
- R9: In the second cycle after a take, execute flags are ignored, but a decode undefined opcode is taken as in R4.
- R10: Cause bits outside [6:2] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_undef | input | 1 | Decode stage holds an undefined opcode |
| id_pc | input | XLEN | PC of the decode-stage instruction |
| ex_ovf | input | 1 | Execute stage arithmetic overflow |
| ex_divz | input | 1 | Execute stage divide by zero |
| ex_pc | input | XLEN | PC of the execute-stage instruction |
| seq_pc | input | XLEN | Next PC chosen by normal fetch |
| next_pc | output | XLEN | PC for the next fetch |
| redirect | output | 1 | Fault taken this cycle |
| flush_ifid | output | 1 | Clear IF/ID control bits |
| flush_idex | output | 1 | Clear ID/EX control bits |
| flush_exmem | output | 1 | Clear EX/MEM control bits (kills the execute instruction's write) |
| epc | output | XLEN | Exception PC register |
| cause | output | XLEN | Cause register, code in bits [6:2] |

## Verification
On every cycle, the assertions check these properties:
- An EX/MEM flush always comes with the two younger flushes.
- A redirect points at the handler vector.
- The recorded PC and code match the stage that was taken.
- The two registers stay stable when nothing is taken.
- No redirect follows a redirect directly.
- The cause register's unused bits stay clear.

Only the bench scenarios can show the arbitration outcomes with concrete values, namely decode against execute and overflow against divide-by-zero. The same holds for the rule that execute flags are ignored in the second cycle after a take while a decode fault is honoured.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_QUIET   = 2'd1,
        ST_PARTIAL = 2'd2
    } exc_state_e;

    localparam int          CODE_W     = 5;
    localparam int          CODE_LSB   = 2;
    localparam logic [4:0]  CODE_UNDEF = 5'h0A;
    localparam logic [4:0]  CODE_OVF   = 5'h0C;
    localparam logic [4:0]  CODE_DIVZ  = 5'h0D;
endpackage

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       id_take,
    output exc_state_e state,
    output logic       ex_en,
    output logic       id_en
);
    exc_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:     nxt = take ? ST_QUIET : ST_RUN;
            ST_QUIET:   nxt = ST_PARTIAL;
            ST_PARTIAL: nxt = id_take ? ST_QUIET : ST_RUN;
            default:    nxt = ST_RUN;
        endcase
    end

    always_comb begin
        ex_en = 1'b0;
        id_en = 1'b0;
        unique case (state)
            ST_RUN:     begin ex_en = 1'b1; id_en = 1'b1; end
            ST_QUIET:   begin ex_en = 1'b0; id_en = 1'b0; end
            ST_PARTIAL: begin ex_en = 1'b0; id_en = 1'b1; end
            default:    begin ex_en = 1'b0; id_en = 1'b0; end
        endcase
    end
endmodule

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              ex_en,
    input  logic              id_en,
    input  logic              id_undef,
    input  logic              ex_ovf,
    input  logic              ex_divz,
    input  logic [XLEN-1:0]   id_pc,
    input  logic [XLEN-1:0]   ex_pc,
    output logic              take,
    output logic              ex_take,
    output logic              id_take,
    output logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   fault_pc
);
    logic ex_hit;
    logic id_hit;

    assign ex_hit = ex_en & (ex_ovf | ex_divz);
    assign id_hit = id_en & id_undef;

    always_comb begin
        ex_take  = 1'b0;
        id_take  = 1'b0;
        code     = '0;
        fault_pc = '0;
        if (ex_hit) begin
            ex_take  = 1'b1;
            code     = ex_ovf ? CODE_OVF : CODE_DIVZ;
            fault_pc = ex_pc;
        end else if (id_hit) begin
            id_take  = 1'b1;
            code     = CODE_UNDEF;
            fault_pc = id_pc;
        end
    end

    assign take = ex_take | id_take;
endmodule

// File: rtl/exc_regs.sv
module exc_regs
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   fault_pc,
    output logic [XLEN-1:0]   epc,
    output logic [XLEN-1:0]   cause
);
    localparam int HI_W = XLEN - CODE_LSB - CODE_W;

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc    <= '0;
            code_q <= '0;
        end else if (take) begin
            epc    <= fault_pc;
            code_q <= code;
        end
    end

    assign cause = {{HI_W{1'b0}}, code_q, {CODE_LSB{1'b0}}};
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN = 32,
    parameter logic [XLEN-1:0] VEC  = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_ovf,
    input  logic            ex_divz,
    input  logic [XLEN-1:0] ex_pc,
    input  logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] next_pc,
    output logic            redirect,
    output logic            flush_ifid,
    output logic            flush_idex,
    output logic            flush_exmem,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause
);
    exc_state_e        state;
    logic              ex_en, id_en;
    logic              take, ex_take, id_take;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   fault_pc;

    exc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .id_take (id_take),
        .state   (state),
        .ex_en   (ex_en),
        .id_en   (id_en)
    );

    exc_prio #(.XLEN(XLEN)) u_prio (
        .ex_en    (ex_en),
        .id_en    (id_en),
        .id_undef (id_undef),
        .ex_ovf   (ex_ovf),
        .ex_divz  (ex_divz),
        .id_pc    (id_pc),
        .ex_pc    (ex_pc),
        .take     (take),
        .ex_take  (ex_take),
        .id_take  (id_take),
        .code     (code),
        .fault_pc (fault_pc)
    );

    exc_regs #(.XLEN(XLEN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .code     (code),
        .fault_pc (fault_pc),
        .epc      (epc),
        .cause    (cause)
    );

    assign redirect    = take;
    assign next_pc     = take ? VEC : seq_pc;
    assign flush_ifid  = take;
    assign flush_idex  = take;
    assign flush_exmem = ex_take;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
    parameter int              XLEN = 32,
    parameter logic [XLEN-1:0] VEC  = 32'h8000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_undef,
    input logic [XLEN-1:0] id_pc,
    input logic            ex_ovf,
    input logic [XLEN-1:0] ex_pc,
    input logic [XLEN-1:0] next_pc,
    input logic            redirect,
    input logic            flush_ifid,
    input logic            flush_idex,
    input logic            flush_exmem,
    input logic [XLEN-1:0] epc,
    input logic [XLEN-1:0] cause
);
    // R2
    exmem_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_exmem |-> (flush_idex && flush_ifid && redirect));

    // R2
    vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (next_pc == VEC));

    // R5
    ex_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_exmem |=> (epc == $past(ex_pc)) &&
                        (cause[6:2] == ($past(ex_ovf) ? 5'h0C : 5'h0D)));

    // R4
    id_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !flush_exmem) |=> (epc == $past(id_pc)) && (cause[6:2] == 5'h0A) && $past(id_undef));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> ($stable(epc) && $stable(cause)));

    // R8
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    // R10
    cause_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause[1:0] == 2'b00) && (cause[XLEN-1:7] == '0));
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .VEC(VEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_undef    (id_undef),
    .id_pc       (id_pc),
    .ex_ovf      (ex_ovf),
    .ex_pc       (ex_pc),
    .next_pc     (next_pc),
    .redirect    (redirect),
    .flush_ifid  (flush_ifid),
    .flush_idex  (flush_idex),
    .flush_exmem (flush_exmem),
    .epc         (epc),
    .cause       (cause)
);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_undef = 1'b0, ex_ovf = 1'b0, ex_divz = 1'b0;
    logic [31:0] id_pc = '0, ex_pc = '0, seq_pc = '0;
    logic [31:0] next_pc, epc, cause;
    logic        redirect, flush_ifid, flush_idex, flush_exmem;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    exc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .id_undef(id_undef), .id_pc(id_pc),
        .ex_ovf(ex_ovf), .ex_divz(ex_divz), .ex_pc(ex_pc), .seq_pc(seq_pc),
        .next_pc(next_pc), .redirect(redirect), .flush_ifid(flush_ifid),
        .flush_idex(flush_idex), .flush_exmem(flush_exmem),
        .epc(epc), .cause(cause)
    );

    typedef struct packed {
        logic        undef;
        logic        ovf;
        logic        divz;
        logic [31:0] ipc;
        logic [31:0] xpc;
        logic        red;
        logic [2:0]  fl;
        logic [31:0] e_epc;
        logic [31:0] e_cause;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b0, 1'b0, 32'h100, 32'h200, 1'b0, 3'b000, 32'h0,    32'h0,  8'd7},
        '{1'b0, 1'b1, 1'b0, 32'h50,  32'h4C,  1'b1, 3'b111, 32'h4C,   32'h30, 8'd2},
        '{1'b0, 1'b0, 1'b1, 32'h60,  32'h1234,1'b1, 3'b111, 32'h1234, 32'h34, 8'd3},
        '{1'b1, 1'b0, 1'b0, 32'h88,  32'h84,  1'b0 | 1'b1, 3'b110, 32'h88, 32'h28, 8'd4},
        '{1'b1, 1'b1, 1'b0, 32'h300, 32'h2FC, 1'b1, 3'b111, 32'h2FC,  32'h30, 8'd5},
        '{1'b0, 1'b1, 1'b1, 32'h504, 32'h500, 1'b1, 3'b111, 32'h500,  32'h30, 8'd6},
        '{1'b0, 1'b0, 1'b0, 32'h600, 32'h5FC, 1'b0, 3'b000, 32'h500,  32'h30, 8'd7}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string rname(input logic [7:0] n);
        case (n)
            8'd2: return "R2";
            8'd3: return "R3";
            8'd4: return "R4";
            8'd5: return "R5";
            8'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic drive(input logic u, input logic o, input logic d,
                         input logic [31:0] ip, input logic [31:0] xp, input logic [31:0] sp);
        id_undef = u; ex_ovf = o; ex_divz = d; id_pc = ip; ex_pc = xp; seq_pc = sp;
    endtask

    initial begin
        #1_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        seq_pc = 32'h1000;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", epc, 32'h0);
        chk("R1", cause, 32'h0);
        chk("R1", {29'h0, flush_ifid, flush_idex, flush_exmem}, 32'h0);
        chk("R1", next_pc, 32'h1000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            drive(VECS[i].undef, VECS[i].ovf, VECS[i].divz, VECS[i].ipc, VECS[i].xpc, 32'h2000 + i * 4);
            #1;
            chk(rname(VECS[i].req), {31'h0, redirect}, {31'h0, VECS[i].red});
            chk(rname(VECS[i].req), {29'h0, flush_ifid, flush_idex, flush_exmem}, {29'h0, VECS[i].fl});
            chk(rname(VECS[i].req), next_pc, VECS[i].red ? VEC : 32'h2000 + i * 4);
            @(posedge clk);
            #1;
            chk(rname(VECS[i].req), epc, VECS[i].e_epc);
            chk(rname(VECS[i].req), cause, VECS[i].e_cause);
            @(negedge clk);
            drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h3000);
            repeat (2) @(posedge clk);
        end

        // R8 / R9 sequence
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 32'h0, 32'h700, 32'h3000);
        #1;
        chk("R2", {31'h0, redirect}, 32'h1);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b1, 32'h804, 32'h800, 32'h3004);
        #1;
        chk("R8", {28'h0, redirect, flush_ifid, flush_idex, flush_exmem}, 32'h0);
        chk("R8", next_pc, 32'h3004);
        @(posedge clk);
        #1;
        chk("R8", epc, 32'h700);
        chk("R8", cause, 32'h30);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 32'h904, 32'h900, 32'h3008);
        #1;
        chk("R9", {31'h0, redirect}, 32'h0);
        @(posedge clk);
        #1;
        chk("R9", epc, 32'h700);
        // reached RUN again; redo take then PARTIAL with decode fault
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 32'h0, 32'hA00, 32'h3000);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h3000);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 32'hB04, 32'hB00, 32'h3010);
        #1;
        chk("R9", {28'h0, redirect, flush_ifid, flush_idex, flush_exmem}, 32'hE);
        chk("R9", next_pc, VEC);
        @(posedge clk);
        #1;
        chk("R9", epc, 32'hB04);
        chk("R9", cause, 32'h28);
        chk("R10", cause & 32'hFFFF_FF83, 32'h0);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h3000);
        rst_n = 1'b0;
        #1;
        chk("R1", epc, 32'h0);
        chk("R1", cause, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule